// File: doc/BRIEF.md
# Lock-Gated Debug Status and Control Register

This block holds the 32-bit debug status and control word that software reaches through a system-register port. A few fields belong to the block itself: the monitor debug enable at bit 15, the EL0 debug-channel trap enable at bit 12, and the 4-bit method-of-entry code at bits 5:2. The block also carries three read-only status bits that come straight from inputs.

Eleven other bit positions are save/restore windows onto a separate external debug status register. These windows open only while the OS lock input is high. When the lock is high, a read returns the external register's value at those positions. A write drives the external register's write strobe, mask and data, and the external register takes the value on the next clock edge.

When the lock is low, the windows read as zero and writes to them are dropped. An event strobe from the exception logic loads the method-of-entry code, which records why a debug exception was taken.

Top module: `dbg_ctl_reg`

## Requirements
- R1: After reset, the monitor enable (bit 15), the trap enable (bit 12), the method-of-entry field (bits 5:2) and the `bad_combo_o` flag all read as 0.
- R2: While `os_lock_i` is 0, the mirrored positions (mask 0xECE84040: bits 31, 30, 29, 27, 26, 23, 22, 21, 19, 14, 6) read as 0. A software write in that state does not raise `ext_wr_en_o`.
- R3: While `os_lock_i` is 1, the mirrored positions of `sw_rdata_o` equal the same bits of `ext_view_i`. A software write raises `ext_wr_en_o` in the same cycle. In that cycle `ext_wr_mask_o` is 0xECE84040 and `ext_wdata_o` carries the written mirrored bits.
- R4: While the lock is held, two write patterns are treated as illegal. If the written bit 27 is 1 and bit 6 is 0, `ext_wdata_o` carries 1 in both bit 27 and bit 6. If the written bit 26 is 1 and bit 6 is 0, `ext_wdata_o` carries 1 in both bit 26 and bit 6. Either case sets `bad_combo_o`, which then stays at 1 until reset.
- R5: Bits 18, 17 and 16 of `sw_rdata_o` always equal `nonsec_i`, `prof_block_i` and `selfdbg_block_i`. Writes do not change them.
- R6: Bit 15 is read/write, and `mon_en_o` follows the stored value.
- R7: Bit 12 is read/write, and `el0_trap_o` follows the stored value. `el0_dtr_trap_o` equals bit 12 AND NOT `in_debug_i`.
- R8: On `exc_evt_i`, bits 5:2 load a code chosen by `exc_kind_i`: 0 gives 0001 (breakpoint), 1 gives 0011 (software breakpoint instruction), 2 gives 0101 (vector catch), 3 gives 1010 (watchpoint). Software writes can also load bits 5:2.
- R9: If a software write and `exc_evt_i` fall in the same cycle, bits 5:2 take the event's code. The write still updates bits 15 and 12.
- R10: The reserved bits (mask 0x13102F83: bits 28, 25, 24, 20, 13, 11:7, 1:0) always read as 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Current register image (combinational read) |
| os_lock_i | input | 1 | OS lock held; opens the mirrored windows |
| ext_view_i | input | 32 | External debug status register, aligned to the same bit positions |
| ext_wr_en_o | output | 1 | Write strobe to the external register |
| ext_wr_mask_o | output | 32 | Bits of the external register to update |
| ext_wdata_o | output | 32 | Data for the external register |
| nonsec_i | input | 1 | Non-secure state status (1 = Non-secure) |
| prof_block_i | input | 1 | Secure privileged profiling prohibited |
| selfdbg_block_i | input | 1 | Secure privileged self-hosted debug disabled |
| exc_evt_i | input | 1 | Debug exception taken strobe |
| exc_kind_i | input | 2 | Cause of the exception (0 breakpoint, 1 software breakpoint, 2 vector catch, 3 watchpoint) |
| in_debug_i | input | 1 | Core is in debug state |
| mon_en_o | output | 1 | Breakpoint/watchpoint/vector catch exceptions enabled |
| el0_trap_o | output | 1 | Trap EL0 accesses to the channel and ID registers |
| el0_dtr_trap_o | output | 1 | Trap EL0 data-transfer accesses, suppressed in debug state |
| bad_combo_o | output | 1 | Sticky flag: an illegal overrun/underrun write was seen |

## Verification
The bench builds the block with its default parameters: a 32-bit register and a 4-bit entry code with the four standard cause values. These defaults cover every mirrored, owned, read-only and reserved position in one image.

A behavioural reference model runs alongside the block, and the directed phases step through each lock state with matching write and view patterns. These phases cover both illegal pairs, alone and together, plus the write/event collision and debug-state gating. A stretch of random traffic then mixes lock toggles, writes and events so that the corner cases also occur back-to-back.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned MOE_W = 4;

  // field positions
  localparam int unsigned P_TFO    = 31;
  localparam int unsigned P_RXF    = 30;
  localparam int unsigned P_TXF    = 29;
  localparam int unsigned P_RXO    = 27;
  localparam int unsigned P_TXU    = 26;
  localparam int unsigned P_IDIS_H = 23;
  localparam int unsigned P_IDIS_L = 22;
  localparam int unsigned P_TDA    = 21;
  localparam int unsigned P_SC2    = 19;
  localparam int unsigned P_NSEC   = 18;
  localparam int unsigned P_PROF   = 17;
  localparam int unsigned P_SDBG   = 16;
  localparam int unsigned P_MON    = 15;
  localparam int unsigned P_HDE    = 14;
  localparam int unsigned P_TRAP   = 12;
  localparam int unsigned P_ERR    = 6;
  localparam int unsigned P_MOE_L  = 2;

  localparam logic [REG_W-1:0] ONE = {{(REG_W-1){1'b0}}, 1'b1};

  localparam logic [REG_W-1:0] MIRROR_MASK =
      (ONE << P_TFO) | (ONE << P_RXF) | (ONE << P_TXF) | (ONE << P_RXO) |
      (ONE << P_TXU) | (ONE << P_IDIS_H) | (ONE << P_IDIS_L) | (ONE << P_TDA) |
      (ONE << P_SC2) | (ONE << P_HDE) | (ONE << P_ERR);

  typedef enum logic [1:0] {
    EXC_BKPT  = 2'd0,
    EXC_SWBK  = 2'd1,
    EXC_VCAT  = 2'd2,
    EXC_WATCH = 2'd3
  } exc_kind_e;
endpackage

// File: rtl/dbg_ctl_own.sv
module dbg_ctl_own
  import dbg_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             mon_en_q,
  output logic             trap_en_q
);
  logic mon_en_d;
  logic trap_en_d;

  always_comb begin
    mon_en_d  = mon_en_q;
    trap_en_d = trap_en_q;
    if (wr_en_i) begin
      mon_en_d  = wdata_i[P_MON];
      trap_en_d = wdata_i[P_TRAP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_en_q  <= 1'b0;
      trap_en_q <= 1'b0;
    end else if (wr_en_i) begin
      mon_en_q  <= mon_en_d;
      trap_en_q <= trap_en_d;
    end
  end
endmodule

// File: rtl/dbg_ctl_moe.sv
module dbg_ctl_moe
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned W = MOE_W,
  parameter logic [W-1:0] CODE_BKPT  = 4'b0001,
  parameter logic [W-1:0] CODE_SWBK  = 4'b0011,
  parameter logic [W-1:0] CODE_VCAT  = 4'b0101,
  parameter logic [W-1:0] CODE_WATCH = 4'b1010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_i,
  input  exc_kind_e    kind_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_code_i,
  output logic [W-1:0] moe_q
);
  logic [W-1:0] evt_code;
  logic [W-1:0] moe_d;
  logic         moe_ce;

  always_comb begin
    unique case (kind_i)
      EXC_BKPT:  evt_code = CODE_BKPT;
      EXC_SWBK:  evt_code = CODE_SWBK;
      EXC_VCAT:  evt_code = CODE_VCAT;
      default:   evt_code = CODE_WATCH;
    endcase
  end

  // event wins over a software write in the same cycle
  always_comb begin
    moe_ce = evt_i | wr_en_i;
    if (evt_i) moe_d = evt_code;
    else       moe_d = wr_code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      moe_q <= '0;
    else if (moe_ce) moe_q <= moe_d;
  end
endmodule

// File: rtl/dbg_ctl_mirror.sv
module dbg_ctl_mirror
  import dbg_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] ext_view_i,
  output logic [REG_W-1:0] rd_view_o,
  output logic             ext_wr_en_o,
  output logic [REG_W-1:0] ext_wr_mask_o,
  output logic [REG_W-1:0] ext_wdata_o,
  output logic             bad_q
);
  logic             rxo_bad;
  logic             txu_bad;
  logic             pass;
  logic [REG_W-1:0] fixed;
  logic             bad_d;

  assign pass    = lock_i & wr_en_i;
  assign rxo_bad = wdata_i[P_RXO] & ~wdata_i[P_ERR];
  assign txu_bad = wdata_i[P_TXU] & ~wdata_i[P_ERR];

  always_comb begin
    fixed = wdata_i & MIRROR_MASK;
    if (rxo_bad) begin
      fixed[P_RXO] = 1'b1;
      fixed[P_ERR] = 1'b1;
    end
    if (txu_bad) begin
      fixed[P_TXU] = 1'b1;
      fixed[P_ERR] = 1'b1;
    end
  end

  assign ext_wr_en_o   = pass;
  assign ext_wr_mask_o = pass ? MIRROR_MASK : '0;
  assign ext_wdata_o   = pass ? fixed : '0;
  assign rd_view_o     = lock_i ? (ext_view_i & MIRROR_MASK) : '0;

  assign bad_d = bad_q | (pass & (rxo_bad | txu_bad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= bad_d;
  end
endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
  import dbg_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en_i,
  input  logic [REG_W-1:0] sw_wdata_i,
  output logic [REG_W-1:0] sw_rdata_o,
  input  logic             os_lock_i,
  input  logic [REG_W-1:0] ext_view_i,
  output logic             ext_wr_en_o,
  output logic [REG_W-1:0] ext_wr_mask_o,
  output logic [REG_W-1:0] ext_wdata_o,
  input  logic             nonsec_i,
  input  logic             prof_block_i,
  input  logic             selfdbg_block_i,
  input  logic             exc_evt_i,
  input  logic [1:0]       exc_kind_i,
  input  logic             in_debug_i,
  output logic             mon_en_o,
  output logic             el0_trap_o,
  output logic             el0_dtr_trap_o,
  output logic             bad_combo_o
);
  logic             mon_en_q;
  logic             trap_en_q;
  logic [MOE_W-1:0] moe_q;
  logic [REG_W-1:0] mir_view;
  logic [REG_W-1:0] own_view;

  dbg_ctl_own i_own (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (sw_wr_en_i),
    .wdata_i   (sw_wdata_i),
    .mon_en_q  (mon_en_q),
    .trap_en_q (trap_en_q)
  );

  dbg_ctl_moe i_moe (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (exc_evt_i),
    .kind_i    (exc_kind_e'(exc_kind_i)),
    .wr_en_i   (sw_wr_en_i),
    .wr_code_i (sw_wdata_i[P_MOE_L +: MOE_W]),
    .moe_q     (moe_q)
  );

  dbg_ctl_mirror i_mir (
    .clk           (clk),
    .rst_n         (rst_n),
    .lock_i        (os_lock_i),
    .wr_en_i       (sw_wr_en_i),
    .wdata_i       (sw_wdata_i),
    .ext_view_i    (ext_view_i),
    .rd_view_o     (mir_view),
    .ext_wr_en_o   (ext_wr_en_o),
    .ext_wr_mask_o (ext_wr_mask_o),
    .ext_wdata_o   (ext_wdata_o),
    .bad_q         (bad_combo_o)
  );

  always_comb begin
    own_view                       = '0;
    own_view[P_NSEC]               = nonsec_i;
    own_view[P_PROF]               = prof_block_i;
    own_view[P_SDBG]               = selfdbg_block_i;
    own_view[P_MON]                = mon_en_q;
    own_view[P_TRAP]               = trap_en_q;
    own_view[P_MOE_L +: MOE_W]     = moe_q;
  end

  assign sw_rdata_o     = own_view | mir_view;
  assign mon_en_o       = mon_en_q;
  assign el0_trap_o     = trap_en_q;
  assign el0_dtr_trap_o = trap_en_q & ~in_debug_i;
endmodule

// File: rtl/dbg_ctl_chk.sv
module dbg_ctl_chk
  import dbg_ctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sw_wr_en_i,
  input logic [REG_W-1:0] sw_wdata_i,
  input logic [REG_W-1:0] sw_rdata_o,
  input logic             os_lock_i,
  input logic [REG_W-1:0] ext_view_i,
  input logic             ext_wr_en_o,
  input logic [REG_W-1:0] ext_wr_mask_o,
  input logic [REG_W-1:0] ext_wdata_o,
  input logic             nonsec_i,
  input logic             prof_block_i,
  input logic             selfdbg_block_i,
  input logic             exc_evt_i,
  input logic [1:0]       exc_kind_i,
  input logic             in_debug_i,
  input logic             mon_en_o,
  input logic             el0_trap_o,
  input logic             el0_dtr_trap_o,
  input logic             bad_combo_o
);
  localparam logic [REG_W-1:0] RSVD = 32'h1310_2F83;

  a_r2_no_strobe_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !os_lock_i |-> !ext_wr_en_o);

  a_r3_strobe_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (os_lock_i && sw_wr_en_i) |-> ext_wr_en_o);

  a_r4_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bad_combo_o |=> bad_combo_o);

  a_r4_pair_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wr_en_o && sw_wdata_i[27] && !sw_wdata_i[6]) |-> (ext_wdata_o[27] && ext_wdata_o[6]));

  a_r5_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rdata_o[18:16] == {nonsec_i, prof_block_i, selfdbg_block_i});

  a_r6_mon_write: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en_i |=> mon_en_o == $past(sw_wdata_i[15]));

  a_r7_dtr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug_i |-> !el0_dtr_trap_o);

  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_evt_i && exc_kind_i == 2'd3) |=> sw_rdata_o[5:2] == 4'b1010);

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata_o & RSVD) == '0);
endmodule

bind dbg_ctl_reg dbg_ctl_chk i_chk (.*);

// File: tb/test_dbg_ctl_reg.sv
module test_dbg_ctl_reg;
  localparam logic [31:0] MIR  = 32'hECE8_4040;
  localparam logic [31:0] RSVD = 32'h1310_2F83;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en_i = 1'b0;
  logic [31:0] sw_wdata_i = '0;
  logic [31:0] sw_rdata_o;
  logic        os_lock_i = 1'b0;
  logic [31:0] ext_view_i = '0;
  logic        ext_wr_en_o;
  logic [31:0] ext_wr_mask_o;
  logic [31:0] ext_wdata_o;
  logic        nonsec_i = 1'b0;
  logic        prof_block_i = 1'b0;
  logic        selfdbg_block_i = 1'b0;
  logic        exc_evt_i = 1'b0;
  logic [1:0]  exc_kind_i = '0;
  logic        in_debug_i = 1'b0;
  logic        mon_en_o;
  logic        el0_trap_o;
  logic        el0_dtr_trap_o;
  logic        bad_combo_o;

  always #2 clk = ~clk;

  dbg_ctl_reg i_dbg_ctl_reg (.*);

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  bit       m_mon, m_trap, m_bad;
  bit [3:0] m_moe;

  function automatic bit [3:0] code_of(input bit [1:0] k);
    case (k)
      2'd0: return 4'b0001;
      2'd1: return 4'b0011;
      2'd2: return 4'b0101;
      default: return 4'b1010;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] er;
    logic [31:0] ew;
    bit          we;
    er = (os_lock_i ? (ext_view_i & MIR) : 32'h0) |
         ({29'h0, nonsec_i, prof_block_i, selfdbg_block_i} << 16) |
         (32'(m_mon) << 15) | (32'(m_trap) << 12) | (32'(m_moe) << 2);
    we = sw_wr_en_i && os_lock_i;
    ew = sw_wdata_i & MIR;
    if (sw_wdata_i[27] && !sw_wdata_i[6]) begin ew[27] = 1'b1; ew[6] = 1'b1; end
    if (sw_wdata_i[26] && !sw_wdata_i[6]) begin ew[26] = 1'b1; ew[6] = 1'b1; end
    chk("R2/R3/R5/R6/R7/R8/R10 rdata", sw_rdata_o, er);
    chk("R10 reserved", sw_rdata_o & RSVD, 32'h0);
    chk("R2/R3 ext_wr_en", {31'h0, ext_wr_en_o}, {31'h0, we});
    if (we) begin
      chk("R3 ext_wr_mask", ext_wr_mask_o, MIR);
      chk("R3/R4 ext_wdata", ext_wdata_o, ew);
    end
    chk("R6 mon_en_o", {31'h0, mon_en_o}, {31'h0, m_mon});
    chk("R7 el0_trap_o", {31'h0, el0_trap_o}, {31'h0, m_trap});
    chk("R7 el0_dtr_trap_o", {31'h0, el0_dtr_trap_o}, {31'h0, m_trap & ~in_debug_i});
    chk("R4 bad_combo_o", {31'h0, bad_combo_o}, {31'h0, m_bad});
  endtask

  // inputs are set at negedge; compare, then take the edge
  task automatic cyc();
    bit hit;
    #1;
    compare_all();
    @(posedge clk);
    hit = sw_wr_en_i && os_lock_i &&
          ((sw_wdata_i[27] || sw_wdata_i[26]) && !sw_wdata_i[6]);
    if (sw_wr_en_i) begin
      m_mon  = sw_wdata_i[15];
      m_trap = sw_wdata_i[12];
      m_moe  = sw_wdata_i[5:2];
    end
    if (exc_evt_i) m_moe = code_of(exc_kind_i);
    if (hit) m_bad = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle();
    sw_wr_en_i = 1'b0;
    exc_evt_i  = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    sw_wr_en_i = 1'b1;
    sw_wdata_i = d;
    cyc();
    idle();
  endtask

  initial begin
    #40000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_mon = 0; m_trap = 0; m_bad = 0; m_moe = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    chk("R1 rdata in reset", sw_rdata_o, 32'h0);
    chk("R1 bad_combo in reset", {31'h0, bad_combo_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc();

    // R2/R10/R6/R7: unlocked write of all ones
    ext_view_i = 32'hFFFF_FFFF;
    wr(32'hFFFF_FFFF);
    cyc();
    chk("R2 mirror hidden unlocked", sw_rdata_o & MIR, 32'h0);
    chk("R4 no flag while unlocked", {31'h0, bad_combo_o}, 32'h0);

    // R5: status inputs, writes of zero do not touch them
    nonsec_i = 1'b1; selfdbg_block_i = 1'b1;
    wr(32'h0);
    cyc();
    prof_block_i = 1'b1; nonsec_i = 1'b0;
    cyc();

    // R3: locked reads and write-through
    os_lock_i = 1'b1;
    ext_view_i = 32'hA5A5_5A5A;
    cyc();
    ext_view_i = 32'h5A5A_A5A5;
    cyc();
    wr(32'hECE8_4040);
    wr(32'h2028_8040);

    // R4: illegal pairs
    wr(32'h0800_0000);
    chk("R4 flag after RX pair", {31'h0, bad_combo_o}, 32'h1);
    wr(32'h0400_0000);
    wr(32'h0C00_0040);
    wr(32'h0C00_0000);
    os_lock_i = 1'b0;
    cyc();

    // R8: event codes
    for (int k = 0; k < 4; k++) begin
      exc_evt_i = 1'b1;
      exc_kind_i = 2'(k);
      cyc();
      idle();
      cyc();
    end

    // R9: event and write collide
    exc_evt_i = 1'b1; exc_kind_i = 2'd2;
    wr(32'h0000_903C);
    cyc();
    chk("R9 event code wins", {28'h0, sw_rdata_o[5:2]}, 32'h5);
    chk("R9 write still sets mon", {31'h0, mon_en_o}, 32'h1);

    // R7: debug-state suppression
    in_debug_i = 1'b1;
    cyc();
    in_debug_i = 1'b0;
    cyc();

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      sw_wr_en_i      = ($urandom % 3) == 0;
      sw_wdata_i      = $urandom;
      os_lock_i       = $urandom % 2;
      ext_view_i      = $urandom;
      exc_evt_i       = ($urandom % 4) == 0;
      exc_kind_i      = 2'($urandom);
      in_debug_i      = $urandom % 2;
      nonsec_i        = $urandom % 2;
      prof_block_i    = $urandom % 2;
      selfdbg_block_i = $urandom % 2;
      cyc();
    end
    idle();
    cyc();

    // R1: reset again clears owned state and the sticky flag
    rst_n = 1'b0;
    #1;
    m_mon = 0; m_trap = 0; m_moe = 0; m_bad = 0;
    chk("R1 owned bits after reset", sw_rdata_o & 32'h0000_903C, 32'h0);
    chk("R1 flag after reset", {31'h0, bad_combo_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule